// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block sits between the bus write decoder and the page-write engine of a byte-wide non-volatile memory. It decides, one byte write at a time, whether each write may reach the page buffer. A write that may go on is passed through as a strobe. A write that protection blocks is turned into a strobe that starts a dummy programming cycle, so read-side status still reports busy for one programming period. Writes that form part of a command are held back and produce neither strobe.

Two commands are recognised. Both are keyed on two fixed addresses: K_HI = 0x5555 and K_LO = 0x2AAA. The arm command is K_HI/0xAA, K_LO/0x55, K_HI/0xA0. The release command is K_HI/0xAA, K_LO/0x55, K_HI/0x80, K_HI/0xAA, K_LO/0x55, K_HI/0x20. Each step must arrive within WIN_CYC cycles of the step before it.

The arm command turns on a protection flag PROG_CYC cycles later. The flag lives in its own reset domain and is cleared only by the power-on-clear input. While the flag is set, the arm command also serves as a per-operation unlock: it opens a page-load window for the writes that follow it.

Top module: `wrprot_seq`

## Requirements
- R1: After por_n is held low, prot_on is 0 and no strobe is active. While prot_on is 0, a write that is not a command step asserts pass_stb in its own cycle and leaves dummy_stb low.
- R2: A complete arm command issued while prot_on is 0 sets prot_on at the clock edge that ends the PROG_CYC-th cycle after the cycle of its third write.
- R3: A write accepted as a command step asserts neither pass_stb nor dummy_stb.
- R4: While prot_on is 1, a write outside an open page-load window that is not a command step asserts dummy_stb in its own cycle and not pass_stb.
- R5: Once the arm command completes, the sequencer opens a page-load window. Every following write passes as long as its strobe comes no more than WIN_CYC cycles after the previous strobe. The window closes after a longer gap, and a protected write after that is blocked.
- R6: A complete release command clears prot_on at the edge of its sixth write's cycle.
- R7: rst_n does not change prot_on. Only por_n clears it.
- R8: A command step whose strobe comes more than WIN_CYC cycles after the previous step is not accepted. The sequencer has returned to idle, and the write is handled as ordinary data.
- R9: A write that does not match the expected next step returns the sequencer to idle. That write is ordinary data: it passes when unprotected and is blocked with a dummy cycle when protected.
- R10: While rst_n is low, writes produce no strobe, and a partly entered command is discarded.
- R11: pass_stb and dummy_stb are never high together, and neither is high without wr_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the command sequencer |
| por_n | input | 1 | Synchronous active-low power-on clear of the protection flag |
| wr_stb | input | 1 | One-cycle decoded byte-write strobe |
| wr_addr | input | AW (15) | Byte address of the write |
| wr_data | input | DW (8) | Data byte of the write |
| pass_stb | output | 1 | Write is allowed through to the page buffer |
| dummy_stb | output | 1 | Blocked write: start a programming period that stores nothing |
| prot_on | output | 1 | Protection flag |

## Verification
The bench targets these boundaries:
- Window gap: a step exactly WIN_CYC cycles after the previous one is accepted, and one cycle later it is not. An off-by-one timer would either drop valid page data or accept a stale command.
- Arming edge: prot_on is checked in the cycle before and the cycle after it should rise. A miscounted arm delay shows up as a one-cycle shift.
- Mismatch handling: a stray write in the middle of a command is checked under both protection states. A design that swallowed the write, or passed it while protected, would lose data or defeat protection.
- Reset split: the bench checks that rst_n leaves protection set while discarding a half-entered command, and that por_n clears the flag.

// File: rtl/wrprot_pkg.sv
// Shared types and command constants for the software write-protect sequencer.
// Assumes 8-bit data and command addresses that fit in the address width.
package wrprot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // no command in progress
        ST_K1,     // first key seen
        ST_K2,     // second key seen
        ST_D3,     // release: third byte seen
        ST_D4,     // release: fourth byte seen
        ST_D5,     // release: fifth byte seen
        ST_OPEN    // page-load window after an arm command
    } seq_state_t;

    localparam logic [15:0] KEY_ADDR_HI = 16'h5555;
    localparam logic [15:0] KEY_ADDR_LO = 16'h2AAA;

    localparam logic [7:0] KEY_BYTE_1   = 8'hAA;
    localparam logic [7:0] KEY_BYTE_2   = 8'h55;
    localparam logic [7:0] KEY_BYTE_ARM = 8'hA0;
    localparam logic [7:0] KEY_BYTE_REL = 8'h80;
    localparam logic [7:0] KEY_BYTE_END = 8'h20;

    // Index of each distinct address/data pattern in the hit vector.
    localparam int PAT_K1  = 0;
    localparam int PAT_K2  = 1;
    localparam int PAT_ARM = 2;
    localparam int PAT_REL = 3;
    localparam int PAT_END = 4;
    localparam int NUM_PAT = 5;

    // Address of pattern idx.
    function automatic logic [15:0] pat_addr(input int idx);
        return (idx == PAT_K2) ? KEY_ADDR_LO : KEY_ADDR_HI;
    endfunction

    // Data byte of pattern idx.
    function automatic logic [7:0] pat_data(input int idx);
        case (idx)
            PAT_K1:  return KEY_BYTE_1;
            PAT_K2:  return KEY_BYTE_2;
            PAT_ARM: return KEY_BYTE_ARM;
            PAT_REL: return KEY_BYTE_REL;
            default: return KEY_BYTE_END;
        endcase
    endfunction

endpackage

// File: rtl/wrprot_step_match.sv
// Compares one write's address and data against every command pattern.
// Purely combinational; one hit bit per pattern, at most one set at a time.
module wrprot_step_match
    import wrprot_pkg::*;
#(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      data,
    output logic [NUM_PAT-1:0] hit
);

    for (genvar i = 0; i < NUM_PAT; i++) begin : g_pat
        localparam logic [15:0] P_ADDR = pat_addr(i);
        localparam logic [7:0]  P_DATA = pat_data(i);

        // Pattern i matches when both fields are equal.
        assign hit[i] = (addr == AW'(P_ADDR)) && (data == DW'(P_DATA));
    end

endmodule

// File: rtl/wrprot_win_timer.sv
// Load-window timer. Counts idle cycles since the last write while the
// sequencer is away from idle. Flags expiry in the WIN_CYC-th cycle after the
// last write when no write arrives in that cycle.
// Assumes WIN_CYC >= 2.
module wrprot_win_timer #(
    parameter int WIN_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic expire
);

    localparam int CW = $clog2(WIN_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Expiry: last idle cycle of the window with no write in it.
    assign expire = run && !restart && (cnt_q == LAST);

    // Idle-cycle counter, cleared by every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run && !expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wrprot_prot_flag.sv
// Persistent protection flag with its arming delay. Only por_n resets it.
// An arm request starts a PROG_CYC-cycle delay, then sets the flag.
// A clear request drops the flag at once and cancels a pending arm.
// Assumes PROG_CYC >= 2.
module wrprot_prot_flag #(
    parameter int PROG_CYC = 32
) (
    input  logic clk,
    input  logic por_n,
    input  logic arm_req,
    input  logic clr_req,
    output logic prot_on,
    output logic arming
);

    localparam int CW = $clog2(PROG_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(PROG_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          prot_q;
    logic          arm_q;

    assign prot_on = prot_q;
    assign arming  = arm_q;

    // Flag, arming state and delay counter, all in the power-on domain.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            prot_q <= 1'b0;
            arm_q  <= 1'b0;
            cnt_q  <= '0;
        end else if (clr_req) begin
            prot_q <= 1'b0;
            arm_q  <= 1'b0;
            cnt_q  <= '0;
        end else if (arm_req && !prot_q) begin
            arm_q <= 1'b1;
            cnt_q <= '0;
        end else if (arm_q) begin
            if (cnt_q == LAST) begin
                prot_q <= 1'b1;
                arm_q  <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wrprot_seq.sv
// Software write-protect command sequencer (top).
// Classifies each byte write as:
//   - a command step: consumed, no strobe;
//   - page data after an arm command: passed through;
//   - ordinary data: passed through when unprotected, otherwise blocked
//     with a dummy programming strobe.
// Assumes wr_stb is a one-cycle strobe per byte with address and data valid
// in the same cycle. Outputs are combinational from the write inputs.
module wrprot_seq
    import wrprot_pkg::*;
#(
    parameter int AW       = 15,
    parameter int DW       = 8,
    parameter int WIN_CYC  = 16,
    parameter int PROG_CYC = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          pass_stb,
    output logic          dummy_stb,
    output logic          prot_on
);

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic [NUM_PAT-1:0] hit;
    logic             wr_ok;
    logic             expire;
    logic             accept;
    logic             ordinary;
    logic             open_wr;
    logic             en_done;
    logic             dis_done;
    logic             open_q;
    logic             arming;

    assign wr_ok  = wr_stb && rst_n;
    assign open_q = (state_q == ST_OPEN);

    wrprot_step_match #(
        .AW (AW),
        .DW (DW)
    ) u_match (
        .addr (wr_addr),
        .data (wr_data),
        .hit  (hit)
    );

    wrprot_win_timer #(
        .WIN_CYC (WIN_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_ok),
        .run     (state_q != ST_IDLE),
        .expire  (expire)
    );

    wrprot_prot_flag #(
        .PROG_CYC (PROG_CYC)
    ) u_flag (
        .clk     (clk),
        .por_n   (por_n),
        .arm_req (en_done),
        .clr_req (dis_done),
        .prot_on (prot_on),
        .arming  (arming)
    );

    // Next state and classification of the current write.
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        ordinary = 1'b0;
        open_wr  = 1'b0;
        en_done  = 1'b0;
        dis_done = 1'b0;
        if (wr_ok) begin
            state_d  = ST_IDLE;
            ordinary = 1'b1;
            unique case (state_q)
                ST_IDLE: if (hit[PAT_K1]) begin
                    state_d = ST_K1; accept = 1'b1;
                end
                ST_K1: if (hit[PAT_K2]) begin
                    state_d = ST_K2; accept = 1'b1;
                end
                ST_K2: begin
                    if (hit[PAT_ARM]) begin
                        state_d = ST_OPEN; accept = 1'b1; en_done = 1'b1;
                    end else if (hit[PAT_REL]) begin
                        state_d = ST_D3; accept = 1'b1;
                    end
                end
                ST_D3: if (hit[PAT_K1]) begin
                    state_d = ST_D4; accept = 1'b1;
                end
                ST_D4: if (hit[PAT_K2]) begin
                    state_d = ST_D5; accept = 1'b1;
                end
                ST_D5: if (hit[PAT_END]) begin
                    state_d = ST_IDLE; accept = 1'b1; dis_done = 1'b1;
                end
                ST_OPEN: begin
                    state_d = ST_OPEN; open_wr = 1'b1;
                end
                default: ;
            endcase
            if (accept || open_wr) begin
                ordinary = 1'b0;
            end
        end else if (expire) begin
            state_d = ST_IDLE;
        end
    end

    // Write routing to the page-write engine.
    assign pass_stb  = open_wr || (ordinary && !prot_on);
    assign dummy_stb = ordinary && prot_on;

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/wrprot_seq_chk.sv
// Property checker for wrprot_seq, bound to every instance of it.
module wrprot_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic por_n,
    input logic wr_stb,
    input logic pass_stb,
    input logic dummy_stb,
    input logic prot_on,
    input logic accept,
    input logic open_q,
    input logic dis_done,
    input logic arming
);

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !(pass_stb && dummy_stb));

    a_r11_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (pass_stb || dummy_stb) |-> wr_stb);

    a_r3_cmd_quiet: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        accept |-> (!pass_stb && !dummy_stb));

    a_r1_free_pass: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (!prot_on && wr_stb && !accept) |-> pass_stb);

    a_r4_blocked: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (prot_on && wr_stb && !open_q && !accept) |-> dummy_stb);

    a_r6_release: assert property (@(posedge clk) disable iff (!por_n)
        dis_done |=> !prot_on);

    a_r2_armed_first: assert property (@(posedge clk) disable iff (!por_n)
        $rose(prot_on) |-> $past(arming));

    a_r7_reset_keeps: assert property (@(posedge clk) disable iff (!por_n)
        (prot_on && !rst_n) |=> prot_on);

    a_r10_reset_quiet: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |-> (!pass_stb && !dummy_stb));

endmodule

bind wrprot_seq wrprot_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_n     (por_n),
    .wr_stb    (wr_stb),
    .pass_stb  (pass_stb),
    .dummy_stb (dummy_stb),
    .prot_on   (prot_on),
    .accept    (accept),
    .open_q    (open_q),
    .dis_done  (dis_done),
    .arming    (arming)
);

// File: tb/wrprot_seq_tb.sv
`timescale 1ns/1ps
module wrprot_seq_tb;

    localparam int AW       = 15;
    localparam int DW       = 8;
    localparam int WIN_CYC  = 16;
    localparam int PROG_CYC = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          por_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          pass_stb;
    logic          dummy_stb;
    logic          prot_on;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    wrprot_seq #(
        .AW       (AW),
        .DW       (DW),
        .WIN_CYC  (WIN_CYC),
        .PROG_CYC (PROG_CYC)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_n     (por_n),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pass_stb  (pass_stb),
        .dummy_stb (dummy_stb),
        .prot_on   (prot_on)
    );

    // Vector: {gap cycles, addr, data, exp pass, exp dummy, exp prot}
    localparam int NV = 24;
    localparam logic [34:0] VEC [NV] = '{
        {8'd0,  16'h0100, 8'hA1, 1'b1, 1'b0, 1'b0},  // R1 ordinary write passes
        {8'd0,  16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0},  // R3 arm step 1
        {8'd0,  16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0},  // R3 arm step 2
        {8'd0,  16'h5555, 8'hA0, 1'b0, 1'b0, 1'b0},  // R3 arm step 3
        {8'd0,  16'h0200, 8'h22, 1'b1, 1'b0, 1'b0},  // R5 page data
        {8'd40, 16'h0300, 8'h33, 1'b0, 1'b1, 1'b1},  // R4 blocked after arming
        {8'd0,  16'h5555, 8'hAA, 1'b0, 1'b0, 1'b1},  // R3 unlock step 1
        {8'd0,  16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1},  // R3 unlock step 2
        {8'd0,  16'h5555, 8'hA0, 1'b0, 1'b0, 1'b1},  // R3 unlock step 3
        {8'd0,  16'h0400, 8'h44, 1'b1, 1'b0, 1'b1},  // R5 unlocked write
        {8'd15, 16'h0401, 8'h45, 1'b1, 1'b0, 1'b1},  // R5 gap equals window
        {8'd16, 16'h0402, 8'h46, 1'b0, 1'b1, 1'b1},  // R5 gap past window
        {8'd0,  16'h5555, 8'hAA, 1'b0, 1'b0, 1'b1},  // R3 step 1
        {8'd0,  16'h1234, 8'h77, 1'b0, 1'b1, 1'b1},  // R9 mismatch while protected
        {8'd0,  16'h5555, 8'hAA, 1'b0, 1'b0, 1'b1},  // R6 release 1
        {8'd0,  16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1},  // R6 release 2
        {8'd0,  16'h5555, 8'h80, 1'b0, 1'b0, 1'b1},  // R6 release 3
        {8'd0,  16'h5555, 8'hAA, 1'b0, 1'b0, 1'b1},  // R6 release 4
        {8'd0,  16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1},  // R6 release 5
        {8'd0,  16'h5555, 8'h20, 1'b0, 1'b0, 1'b1},  // R6 release 6
        {8'd0,  16'h0500, 8'h55, 1'b1, 1'b0, 1'b0},  // R6 unprotected again
        {8'd0,  16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0},  // R8 step 1
        {8'd16, 16'h2AAA, 8'h55, 1'b1, 1'b0, 1'b0},  // R8 late step is data
        {8'd0,  16'h5555, 8'hA0, 1'b1, 1'b0, 1'b0}   // R8 no arm from idle
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One write cycle, checked before the clock edge that consumes it.
    task automatic wr(input logic [15:0] a, input logic [7:0] d,
                      input logic ep, input logic ed, input logic epr, input string req);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_addr = a[AW-1:0];
        wr_data = d;
        #1;
        chk(req, "pass_stb", int'(pass_stb), int'(ep));
        chk(req, "dummy_stb", int'(dummy_stb), int'(ed));
        chk(req, "prot_on", int'(prot_on), int'(epr));
        @(posedge clk);
        #1 wr_stb = 1'b0;
    endtask

    task automatic pulse_rst;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 200000);
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "prot_on", int'(prot_on), 0);
        chk("R1", "pass_stb", int'(pass_stb), 0);
        chk("R1", "dummy_stb", int'(dummy_stb), 0);

        for (int i = 0; i < NV; i++) begin
            repeat (int'(VEC[i][34:27])) @(posedge clk);
            wr(VEC[i][26:11], VEC[i][10:3], VEC[i][2], VEC[i][1], VEC[i][0],
               $sformatf("vec%0d", i));
        end

        // R2 exact arming edge
        wr(16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, "R2");
        wr(16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, "R2");
        wr(16'h5555, 8'hA0, 1'b0, 1'b0, 1'b0, "R2");
        repeat (PROG_CYC - 1) @(posedge clk);
        #1 chk("R2", "prot_on before edge", int'(prot_on), 0);
        @(posedge clk);
        #1 chk("R2", "prot_on after edge", int'(prot_on), 1);
        repeat (WIN_CYC + 2) @(posedge clk);

        // R7 sequencer reset keeps protection
        pulse_rst();
        #1 chk("R7", "prot_on after rst_n", int'(prot_on), 1);

        // R10 write during reset gives no strobe
        @(negedge clk);
        rst_n = 1'b0;
        wr_stb = 1'b1;
        wr_addr = 15'h0600;
        wr_data = 8'h66;
        #1;
        chk("R10", "pass_stb in reset", int'(pass_stb), 0);
        chk("R10", "dummy_stb in reset", int'(dummy_stb), 0);
        @(posedge clk);
        #1 wr_stb = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        wr(16'h0600, 8'h66, 1'b0, 1'b1, 1'b1, "R7");

        // R10 partial command dropped by rst_n
        wr(16'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, "R10");
        wr(16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1, "R10");
        pulse_rst();
        wr(16'h5555, 8'hA0, 1'b0, 1'b1, 1'b1, "R10");

        // R7 power-on clear drops protection
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        #1 chk("R7", "prot_on after por_n", int'(prot_on), 0);
        wr(16'h0700, 8'h77, 1'b1, 1'b0, 1'b0, "R1");

        // R9 mismatch while unprotected passes
        wr(16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, "R9");
        wr(16'h2AAA, 8'h54, 1'b1, 1'b0, 1'b0, "R9");

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule